// File: doc/BRIEF.md
# Tagged Memory Shim with Tag Cache

This block lets a plain 128-bit backing memory behave as memory whose every data word carries a 129th bit. The tag bits are stored out of band in a small slice of the same backing memory. With the default sizes, 1024 data words need only 8 tag lines, placed just above the data area. A small direct-mapped cache of tag lines inside the block means that most requests reach the backing memory only once, for the data word itself.

Upstream, a requester issues one read or write at a time. Write data and the write tag travel together as a single 129-bit word. A write marked as a capability store keeps the supplied tag bit. Any other write clears the tag. A read returns the data and its tag in one response beat.

Downstream, the block drives a simple valid/ready request port and accepts single-beat read responses. A flush input writes every dirty tag line back to the backing memory, then pulses a done flag.

Top module: `cap_tag_ctrl`

## Requirements
- R1: A read returns exactly one response beat. Bits [127:0] of that beat carry the stored data and bit [128] carries the stored tag. A write also finishes with one response beat, whose data is zero.
- R2: A write with `up_wcap` = 0 leaves the word's tag at 0, even when bit [128] of the write data is 1.
- R3: A write with `up_wcap` = 1 stores bit [128] of the write data as the word's tag. The tag is stored in the same transaction that issues the data write.
- R4: Word index i maps to backing address i, which always has the top address bit at 0. Its tag lives at backing address 2^DATA_AW + i/128, bit i mod 128. The upstream address is DATA_AW bits wide, so it can never select the tag region.
- R5: On a tag-cache miss, the block reads the whole tag line from the backing memory before the data access. A later access whose tag line is still cached issues no tag-region read.
- R6: A miss that displaces a dirty tag line first writes that line back to its own tag address, and only then issues the fill read. A clean victim is dropped without any write.
- R7: A one-cycle `flush_req` writes back every dirty cached tag line and no clean one, then raises `flush_done` for exactly one cycle. This happens even when no line is dirty.
- R8: After reset, `up_req_ready` is 1, and `up_rsp_valid`, `mem_req_valid` and `flush_done` are 0.
- R9: After a request is accepted, `up_req_ready` stays 0 until that request has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Upstream request present |
| up_req_ready | output | 1 | Block can take a request this cycle |
| up_we | input | 1 | 1 = write, 0 = read |
| up_wcap | input | 1 | Write is a capability store; keep the supplied tag |
| up_addr | input | DATA_AW | Data word index |
| up_wdata | input | 129 | Write data [127:0] with tag in bit [128] |
| up_rsp_valid | output | 1 | One-cycle response beat |
| up_rsp_data | output | 129 | Read data with tag in bit [128] |
| flush_req | input | 1 | Write back all dirty tag lines |
| flush_done | output | 1 | One-cycle pulse when the flush is finished |
| mem_req_valid | output | 1 | Backing request present |
| mem_req_ready | input | 1 | Backing memory takes the request |
| mem_we | output | 1 | Backing write |
| mem_addr | output | DATA_AW+1 | Backing word address |
| mem_wdata | output | 128 | Backing write data |
| mem_rsp_valid | input | 1 | Backing read data valid |
| mem_rsp_data | input | 128 | Backing read data |

## Verification
The tag rules are tried with three patterns:

- a capability write with tag 1,
- a plain write whose bit [128] is 1,
- a plain write over an earlier capability word.

Together these separate a design that forces the tag to 0 from one that passes the tag through, and from one that keeps a stale tag.

Cache behaviour is tried with two kinds of access:

- accesses that share a tag line, which must produce no tag traffic;
- accesses to another line in the same set, which must show a write-back only when that set's line is dirty.

The round trip through eviction and refill shows that tags survive leaving the cache. Word 1023 and two back-to-back flushes, one with dirty lines and one without, cover the last bit of the last tag line and the empty flush.

// File: rtl/cap_tag_pkg.sv
package cap_tag_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_FILLW,
    ST_DATA,
    ST_RDW,
    ST_FLUSH,
    ST_FLWB
  } ctl_state_e;
endpackage

// File: rtl/cap_tag_map.sv
module cap_tag_map #(
  parameter int DATA_AW = 10,
  parameter int WORD_W  = 128,
  parameter int SETS    = 2
) (
  input  logic [DATA_AW-1:0]                                     word_idx,
  input  logic [$clog2(SETS)-1:0]                                ln_set,
  input  logic [DATA_AW-$clog2(WORD_W)-$clog2(SETS)-1:0]         ln_ctag,
  output logic [DATA_AW:0]                                       data_addr,
  output logic [$clog2(SETS)-1:0]                                set_idx,
  output logic [DATA_AW-$clog2(WORD_W)-$clog2(SETS)-1:0]         ctag,
  output logic [$clog2(WORD_W)-1:0]                              bit_off,
  output logic [DATA_AW:0]                                       line_addr
);
  localparam int OFF_W   = $clog2(WORD_W);
  localparam int TLINE_W = DATA_AW - OFF_W;
  localparam int SET_W   = $clog2(SETS);
  localparam int MEM_AW  = DATA_AW + 1;

  // Data words occupy the lower half of the backing address space.
  function automatic logic [MEM_AW-1:0] f_data_addr(input logic [DATA_AW-1:0] i);
    return {1'b0, i};
  endfunction

  // Tag line number = word index / bits per line.
  function automatic logic [TLINE_W-1:0] f_tline(input logic [DATA_AW-1:0] i);
    return i[DATA_AW-1:OFF_W];
  endfunction

  // Tag region base is 2^DATA_AW, followed by the line number.
  function automatic logic [MEM_AW-1:0] f_tag_addr(input logic [TLINE_W-1:0] tl);
    return {1'b1, {(DATA_AW-TLINE_W){1'b0}}, tl};
  endfunction

  logic [TLINE_W-1:0] tl;
  assign tl        = f_tline(word_idx);
  assign data_addr = f_data_addr(word_idx);
  assign bit_off   = word_idx[OFF_W-1:0];
  assign set_idx   = tl[SET_W-1:0];
  assign ctag      = tl[TLINE_W-1:SET_W];
  assign line_addr = f_tag_addr({ln_ctag, ln_set});
endmodule

// File: rtl/cap_tag_cache.sv
module cap_tag_cache #(
  parameter int WORD_W = 128,
  parameter int SETS   = 2,
  parameter int CTAG_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(SETS)-1:0]    rd_set,
  output logic                       rd_valid,
  output logic                       rd_dirty,
  output logic [CTAG_W-1:0]          rd_ctag,
  output logic [WORD_W-1:0]          rd_line,
  input  logic                       fill_en,
  input  logic [CTAG_W-1:0]          fill_ctag,
  input  logic [WORD_W-1:0]          fill_line,
  input  logic                       bit_we,
  input  logic [$clog2(WORD_W)-1:0]  bit_off,
  input  logic                       bit_val,
  input  logic                       clean_en
);
  // Fill, bit writes and cleans all act on the set selected by rd_set.
  logic              v_a [SETS];
  logic              d_a [SETS];
  logic [CTAG_W-1:0] t_a [SETS];
  logic [WORD_W-1:0] l_a [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = (rd_set == s[$clog2(SETS)-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_a[s] <= 1'b0;
        d_a[s] <= 1'b0;
        t_a[s] <= '0;
        l_a[s] <= '0;
      end else if (sel) begin
        if (fill_en) begin
          v_a[s] <= 1'b1;
          d_a[s] <= 1'b0;
          t_a[s] <= fill_ctag;
          l_a[s] <= fill_line;
        end else if (bit_we) begin
          l_a[s][bit_off] <= bit_val;
          d_a[s]          <= 1'b1;
        end else if (clean_en) begin
          d_a[s] <= 1'b0;
        end
      end
    end
  end

  assign rd_valid = v_a[rd_set];
  assign rd_dirty = d_a[rd_set];
  assign rd_ctag  = t_a[rd_set];
  assign rd_line  = l_a[rd_set];
endmodule

// File: rtl/cap_tag_ctrl.sv
module cap_tag_ctrl
  import cap_tag_pkg::*;
#(
  parameter int DATA_AW = 10,
  parameter int WORD_W  = 128,
  parameter int SETS    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 up_req_valid,
  output logic                 up_req_ready,
  input  logic                 up_we,
  input  logic                 up_wcap,
  input  logic [DATA_AW-1:0]   up_addr,
  input  logic [WORD_W:0]      up_wdata,
  output logic                 up_rsp_valid,
  output logic [WORD_W:0]      up_rsp_data,
  input  logic                 flush_req,
  output logic                 flush_done,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_we,
  output logic [DATA_AW:0]     mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data
);
  localparam int OFF_W   = $clog2(WORD_W);
  localparam int SET_W   = $clog2(SETS);
  localparam int CTAG_W  = DATA_AW - OFF_W - SET_W;
  localparam int MEM_AW  = DATA_AW + 1;

  ctl_state_e state;

  logic               req_we_q, req_cap_q;
  logic [DATA_AW-1:0] req_addr_q;
  logic [WORD_W:0]    req_wdata_q;
  logic [SET_W-1:0]   fl_set;

  logic [MEM_AW-1:0]  d_addr, ln_addr;
  logic [SET_W-1:0]   r_set, lk_set;
  logic [CTAG_W-1:0]  r_ctag, ln_ctag;
  logic [OFF_W-1:0]   r_off;

  logic               rd_valid, rd_dirty;
  logic [CTAG_W-1:0]  rd_ctag;
  logic [WORD_W-1:0]  rd_line;
  logic               fill_en, bit_we, clean_en, hit, fl_last;

  // Named internal events, used by the bound checker.
  logic data_issue, tag_issue, fill_issue, victim_dirty;

  assign lk_set  = (state == ST_FLUSH || state == ST_FLWB) ? fl_set : r_set;
  // Write-back goes to the victim's own line; a fill goes to the requested line.
  assign ln_ctag = (state == ST_FILL) ? r_ctag : rd_ctag;

  cap_tag_map #(.DATA_AW(DATA_AW), .WORD_W(WORD_W), .SETS(SETS)) u_map (
    .word_idx(req_addr_q), .ln_set(lk_set), .ln_ctag(ln_ctag),
    .data_addr(d_addr), .set_idx(r_set), .ctag(r_ctag), .bit_off(r_off),
    .line_addr(ln_addr)
  );

  cap_tag_cache #(.WORD_W(WORD_W), .SETS(SETS), .CTAG_W(CTAG_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .rd_set(lk_set),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_ctag(rd_ctag), .rd_line(rd_line),
    .fill_en(fill_en), .fill_ctag(r_ctag), .fill_line(mem_rsp_data),
    .bit_we(bit_we), .bit_off(r_off),
    .bit_val(req_cap_q & req_wdata_q[WORD_W]),
    .clean_en(clean_en)
  );

  assign hit          = rd_valid && (rd_ctag == r_ctag);
  assign victim_dirty = rd_valid && rd_dirty;
  assign fl_last      = (fl_set == SET_W'(SETS-1));
  assign up_req_ready = (state == ST_IDLE) && !flush_req;

  assign fill_en  = (state == ST_FILLW) && mem_rsp_valid;
  assign bit_we   = (state == ST_DATA) && req_we_q && mem_req_ready;
  assign clean_en = (state == ST_EVICT || state == ST_FLWB) && mem_req_ready;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = '0;
    mem_wdata     = '0;
    unique case (state)
      ST_EVICT, ST_FLWB: begin
        mem_req_valid = 1'b1;
        mem_we        = 1'b1;
        mem_addr      = ln_addr;
        mem_wdata     = rd_line;
      end
      ST_FILL: begin
        mem_req_valid = 1'b1;
        mem_addr      = ln_addr;
      end
      ST_DATA: begin
        mem_req_valid = 1'b1;
        mem_we        = req_we_q;
        mem_addr      = d_addr;
        mem_wdata     = req_wdata_q[WORD_W-1:0];
      end
      default: ;
    endcase
  end

  assign data_issue = (state == ST_DATA) && mem_req_valid;
  assign tag_issue  = (state == ST_EVICT || state == ST_FILL || state == ST_FLWB) && mem_req_valid;
  assign fill_issue = (state == ST_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      req_we_q     <= 1'b0;
      req_cap_q    <= 1'b0;
      req_addr_q   <= '0;
      req_wdata_q  <= '0;
      fl_set       <= '0;
      up_rsp_valid <= 1'b0;
      up_rsp_data  <= '0;
      flush_done   <= 1'b0;
    end else begin
      up_rsp_valid <= 1'b0;
      flush_done   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (flush_req) begin
            fl_set <= '0;
            state  <= ST_FLUSH;
          end else if (up_req_valid) begin
            req_we_q    <= up_we;
            req_cap_q   <= up_wcap;
            req_addr_q  <= up_addr;
            req_wdata_q <= up_wdata;
            state       <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit)               state <= ST_DATA;
          else if (victim_dirty) state <= ST_EVICT;
          else                   state <= ST_FILL;
        end
        ST_EVICT: if (mem_req_ready) state <= ST_FILL;
        ST_FILL:  if (mem_req_ready) state <= ST_FILLW;
        ST_FILLW: if (mem_rsp_valid) state <= ST_DATA;
        ST_DATA: begin
          if (mem_req_ready) begin
            if (req_we_q) begin
              up_rsp_valid <= 1'b1;
              up_rsp_data  <= '0;
              state        <= ST_IDLE;
            end else begin
              state <= ST_RDW;
            end
          end
        end
        ST_RDW: begin
          if (mem_rsp_valid) begin
            up_rsp_valid <= 1'b1;
            up_rsp_data  <= {rd_line[r_off], mem_rsp_data};
            state        <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (victim_dirty) begin
            state <= ST_FLWB;
          end else if (fl_last) begin
            flush_done <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            fl_set <= fl_set + 1'b1;
          end
        end
        ST_FLWB: begin
          if (mem_req_ready) begin
            if (fl_last) begin
              flush_done <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              fl_set <= fl_set + 1'b1;
              state  <= ST_FLUSH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

module cap_tag_chk #(
  parameter int MEM_AW = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic              up_rsp_valid,
  input logic              flush_done,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              data_issue,
  input logic              tag_issue,
  input logic              fill_issue,
  input logic              victim_dirty
);
  AST_DATA_BELOW_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    data_issue |-> !mem_addr[MEM_AW-1]); // R4
  AST_TAG_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    tag_issue |-> mem_addr[MEM_AW-1]); // R5
  AST_NO_DIRTY_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_issue |-> !victim_dirty); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done); // R7
  AST_RSP_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |=> !up_rsp_valid); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready) |=> !up_req_ready); // R9
  AST_NO_DATA_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> !data_issue); // R9
endmodule

bind cap_tag_ctrl cap_tag_chk #(.MEM_AW(DATA_AW+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
  .up_rsp_valid(up_rsp_valid), .flush_done(flush_done), .mem_addr(mem_addr),
  .data_issue(data_issue), .tag_issue(tag_issue), .fill_issue(fill_issue),
  .victim_dirty(victim_dirty)
);

// File: tb/tb_cap_tag_ctrl.sv
module tb_cap_tag_ctrl;
  localparam int AW = 10;
  localparam int NW = 1 << AW;
  localparam int TB = NW;          // tag region base
  localparam int MW = NW + NW/128; // backing words actually used

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_req_valid = 0, up_we = 0, up_wcap = 0, flush_req = 0;
  logic [AW-1:0] up_addr = '0;
  logic [128:0]  up_wdata = '0;
  logic up_req_ready, up_rsp_valid, flush_done;
  logic [128:0] up_rsp_data;
  logic mem_req_valid, mem_we, mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
  logic [AW:0]   mem_addr;
  logic [127:0]  mem_wdata, mem_rsp_data = '0;

  logic [127:0] mem [MW];
  int tag_rd = 0, tag_wr = 0, last_daddr = -1, cyc = 0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cap_tag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_we(up_we), .up_wcap(up_wcap), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_data(up_rsp_data), .flush_req(flush_req),
    .flush_done(flush_done), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Backing memory model with occasional stalls.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 2;
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (int'(mem_addr) >= TB) begin
        if (mem_we) tag_wr <= tag_wr + 1; else tag_rd <= tag_rd + 1;
      end else begin
        last_daddr <= int'(mem_addr);
      end
      if (mem_we) begin
        mem[int'(mem_addr)] <= mem_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[int'(mem_addr)];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [128:0] act, input logic [128:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int tag_line(input int i);
    return TB + i / 128;
  endfunction

  task automatic issue(input bit we, input bit cap, input int a, input logic [128:0] wd, output logic [128:0] rsp);
    @(negedge clk);
    up_req_valid = 1; up_we = we; up_wcap = cap; up_addr = AW'(a); up_wdata = wd;
    while (!up_req_ready) @(negedge clk);
    @(negedge clk);
    up_req_valid = 0;
    check(up_req_ready == 1'b0, "R9 busy after accept", {128'b0, up_req_ready}, 129'd0);
    while (!up_rsp_valid) @(negedge clk);
    rsp = up_rsp_data;
    @(negedge clk);
    check(up_rsp_valid == 1'b0, "R1 single beat", {128'b0, up_rsp_valid}, 129'd0);
  endtask

  task automatic do_flush(output int nwr);
    int w0;
    @(negedge clk);
    while (!up_req_ready) @(negedge clk);
    w0 = tag_wr;
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    while (!flush_done) @(negedge clk);
    nwr = tag_wr - w0;
    @(negedge clk);
    check(flush_done == 1'b0, "R7 done one cycle", {128'b0, flush_done}, 129'd0);
  endtask

  task automatic t_reset();
    check(up_req_ready === 1'b1, "R8 ready", {128'b0, up_req_ready}, 129'd1);
    check(up_rsp_valid === 1'b0 && mem_req_valid === 1'b0 && flush_done === 1'b0,
          "R8 idle outputs", {126'b0, up_rsp_valid, mem_req_valid, flush_done}, 129'd0);
  endtask

  task automatic t_cap_and_plain();
    logic [128:0] r;
    int r0;
    logic [127:0] dA = 128'hA5A5_0001_0000_0000_0000_0000_1234_5678;
    r0 = tag_rd;
    issue(1, 1, 5, {1'b1, dA}, r);
    check(tag_rd - r0 == 1, "R5 miss fills line", 129'(tag_rd - r0), 129'd1);
    check(last_daddr == 5, "R4 data address", 129'(last_daddr), 129'd5);
    issue(0, 0, 5, '0, r);
    check(r == {1'b1, dA}, "R3 cap write keeps tag / R1 read beat", r, {1'b1, dA});
    issue(1, 0, 6, {1'b1, 128'hBEEF}, r);
    issue(0, 0, 6, '0, r);
    check(r == {1'b0, 128'hBEEF}, "R2 plain write clears tag", r, {1'b0, 128'hBEEF});
    issue(1, 0, 5, {1'b1, 128'hC0DE}, r);
    issue(0, 0, 5, '0, r);
    check(r == {1'b0, 128'hC0DE}, "R2 plain over capability", r, {1'b0, 128'hC0DE});
    r0 = tag_rd;
    issue(0, 0, 7, '0, r);
    check(tag_rd == r0, "R5 hit has no tag read", 129'(tag_rd - r0), 129'd0);
    check(r == {1'b0, mem[7]}, "R1 untouched word", r, {1'b0, mem[7]});
  endtask

  task automatic t_evict();
    logic [128:0] r;
    int w0;
    issue(1, 1, 9, {1'b1, 128'h9999}, r);
    w0 = tag_wr;
    issue(0, 0, 300, '0, r);
    check(tag_wr - w0 == 1, "R6 dirty victim written back", 129'(tag_wr - w0), 129'd1);
    check(mem[tag_line(9)][9] == 1'b1 && mem[tag_line(5)][5] == 1'b0,
          "R6 written line content", {127'b0, mem[TB][9], mem[TB][5]}, 129'd2);
    check(last_daddr == 300, "R4 data address 300", 129'(last_daddr), 129'd300);
    w0 = tag_wr;
    issue(0, 0, 9, '0, r);
    check(tag_wr == w0, "R6 clean victim not written", 129'(tag_wr - w0), 129'd0);
    check(r == {1'b1, 128'h9999}, "R6 tag survives eviction", r, {1'b1, 128'h9999});
  endtask

  task automatic t_flush();
    logic [128:0] r;
    int n;
    issue(1, 1, 200, {1'b1, 128'h200}, r);
    do_flush(n);
    check(n == 1, "R7 one dirty line flushed", 129'(n), 129'd1);
    check(mem[tag_line(200)][200 % 128] == 1'b1, "R7 flushed bit at line 1 bit 72",
          {128'b0, mem[tag_line(200)][72]}, 129'd1);
    do_flush(n);
    check(n == 0, "R7 empty flush writes nothing", 129'(n), 129'd0);
  endtask

  task automatic t_top_word();
    logic [128:0] r;
    int n;
    issue(1, 1, NW - 1, {1'b1, 128'hFFFF_0000}, r);
    issue(0, 0, NW - 1, '0, r);
    check(r == {1'b1, 128'hFFFF_0000}, "R3 top word tag", r, {1'b1, 128'hFFFF_0000});
    do_flush(n);
    check(mem[tag_line(NW - 1)][127] == 1'b1, "R4 last line last bit",
          {128'b0, mem[tag_line(NW - 1)][127]}, 129'd1);
  endtask

  initial begin
    for (int i = 0; i < MW; i++) mem[i] = (i < NW) ? {4{32'(i * 7 + 3)}} : '0;
    fork
      begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_cap_and_plain();
        t_evict();
        t_flush();
        t_top_word();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule